// File: doc/BRIEF.md
# Serial Bitstream Configuration Master

This block loads a configuration bitstream into a target FPGA over its bit-serial slave configuration pins. It takes bytes from a valid/ready stream and resets the target by pulsing its active-low program pin. It then waits for the target's active-low init pin to fall and rise again. After that it shifts each byte out on a data pin, one bit for each rising edge of a configuration clock that it generates from the system clock.

While data flows, the block watches two inputs. A falling init pin means the target found a checksum error, and the load aborts. A high done pin before a byte means the target needs no more data, and streaming stops early. Once streaming ends, the block keeps clocking ones into the target until done and init are both high, then gives a fixed number of extra clocks and reports success. Every wait is bounded by a cycle-count parameter. A failed load returns the pins to idle and keeps an error code until the next start.

Top module: `sscfg_loader`

## Requirements
- R1: After reset the program pin and the configuration clock are high, and busy, load_ok, load_fail, s_ready and err_code (0) are all low.
- R2: A start pulse in idle drives the program pin low. The pin is released only once the synchronised init pin reads low and at least PROG_CYCLES system cycles have passed. When init is already low, the pulse is exactly PROG_CYCLES cycles long.
- R3: If init is not seen low within INIT_TIMEOUT cycles of the program pin falling, the load fails with err_code 1 and the program pin returns high.
- R4: After release, no byte is accepted and no configuration clock edge occurs until init reads high. If init does not rise within INIT_TIMEOUT cycles, the load fails with err_code 2.
- R5: Each accepted byte is sent MSB first, one bit for each rising configuration clock edge. The data pin is stable across every rising edge, and every low phase of the clock lasts CCLK_HALF system cycles.
- R6: If the synchronised done pin is high when the serialiser is ready for another byte, no further byte is accepted and the finishing phase starts.
- R7: If init reads low at any time during streaming, the load fails with err_code 3 and accepts no further byte.
- R8: In the finishing phase the data pin is 1 on every clock. A clock pulse that ends with done and init both high arms the finish. Exactly TRAIL_CLKS (8) further rising edges follow, then load_ok is set with err_code 0.
- R9: If the finishing phase has not completed within CONFIG_TIMEOUT cycles, the load fails with err_code 4.
- R10: load_ok, load_fail and err_code hold until the next accepted start, which clears them. A start pulse while busy has no effect, and the pins are idle (program high, clock high) whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse in idle to begin a load |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | s_data holds a byte |
| s_last | input | 1 | Marks the final byte of the bitstream |
| s_ready | output | 1 | Byte is taken on this cycle when s_valid is high |
| cfg_prog_n | output | 1 | Active-low reset/program pin of the target |
| cfg_init_n | input | 1 | Target init pin (low = clearing or checksum error) |
| cfg_done | input | 1 | Target done pin |
| cfg_cclk | output | 1 | Configuration clock, idle high |
| cfg_din | output | 1 | Serial configuration data |
| busy | output | 1 | A load is in progress |
| load_ok | output | 1 | Sticky: last load succeeded |
| load_fail | output | 1 | Sticky: last load failed |
| err_code | output | 3 | 0 none, 1 init never fell, 2 init never rose, 3 checksum error, 4 finish timeout |

## Verification
Byte acceptance can coincide with the done check (R6) and with the error check (R7): both are decided on the cycle the serialiser frees up after a byte. The bench provokes this by raising done, or dropping init, right after the last rising clock edge of a chosen byte. That change reaches the block inside the same high phase that ends the byte. The outcome is judged by the number of bytes taken on the stream, which must equal the chosen byte index exactly, and by the final status and error code.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_PROG,
    LD_WAIT_INIT,
    LD_STREAM,
    LD_FINISH
  } ld_state_e;

  typedef enum logic [2:0] {
    ERR_NONE           = 3'd0,
    ERR_NO_INIT_LOW    = 3'd1,
    ERR_NO_INIT_HIGH   = 3'd2,
    ERR_CRC            = 3'd3,
    ERR_FINISH_TIMEOUT = 3'd4
  } ld_err_e;
endpackage

// File: rtl/sscfg_sync.sv
module sscfg_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sscfg_cycle_timer.sv
module sscfg_cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)     cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sscfg_shifter.sv
module sscfg_shifter #(
  parameter int HALF = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         stop,
  output logic         cclk,
  output logic         din,
  output logic         busy,
  output logic         pulse_end
);
  localparam int PH_W  = (2 * HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(2 * HALF - 1);
  localparam logic [PH_W-1:0]  PH_RISE = PH_W'(HALF);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] BITS_ONE  = CNT_W'(1);

  logic [W-2:0]     sh;
  logic [CNT_W-1:0] bits;
  logic [PH_W-1:0]  ph, ph_n;

  assign ph_n      = (ph == PH_LAST) ? '0 : ph + 1'b1;
  assign busy      = (bits != '0);
  assign pulse_end = busy && (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      bits <= '0;
      ph   <= '0;
      cclk <= 1'b1;
      din  <= 1'b1;
    end else if (stop) begin
      bits <= '0;
      ph   <= '0;
      cclk <= 1'b1;
    end else if (load) begin
      sh   <= load_byte[W-2:0];
      bits <= BITS_FULL;
      ph   <= '0;
      cclk <= 1'b0;
      din  <= load_byte[W-1];
    end else if (busy) begin
      ph <= ph_n;
      if (ph == PH_LAST) begin
        bits <= bits - 1'b1;
        if (bits > BITS_ONE) begin
          din  <= sh[W-2];
          sh   <= {sh[W-3:0], 1'b0};
          cclk <= 1'b0;
        end
      end else if (ph_n == PH_RISE) begin
        cclk <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sscfg_loader.sv
module sscfg_loader import sscfg_pkg::*; #(
  parameter int CCLK_HALF      = 4,
  parameter int PROG_CYCLES    = 75,
  parameter int INIT_TIMEOUT   = 125_000_000,
  parameter int CONFIG_TIMEOUT = 50_000_000,
  parameter int TRAIL_CLKS     = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              cfg_prog_n,
  input  logic              cfg_init_n,
  input  logic              cfg_done,
  output logic              cfg_cclk,
  output logic              cfg_din,
  output logic              busy,
  output logic              load_ok,
  output logic              load_fail,
  output logic [2:0]        err_code
);
  localparam int LIM_A   = (INIT_TIMEOUT > CONFIG_TIMEOUT) ? INIT_TIMEOUT : CONFIG_TIMEOUT;
  localparam int LIM_MAX = (LIM_A > PROG_CYCLES) ? LIM_A : PROG_CYCLES;
  localparam int TMR_W   = $clog2(LIM_MAX + 1);
  localparam int TRAIL_W = $clog2(TRAIL_CLKS + 1);
  localparam logic [TMR_W-1:0]   PROG_END = TMR_W'(PROG_CYCLES - 1);
  localparam logic [TMR_W-1:0]   INIT_END = TMR_W'(INIT_TIMEOUT - 1);
  localparam logic [TMR_W-1:0]   CFG_END  = TMR_W'(CONFIG_TIMEOUT - 1);
  localparam logic [TRAIL_W-1:0] TRAIL_END = TRAIL_W'(TRAIL_CLKS - 1);

  ld_state_e st, st_n;
  ld_err_e   err_q, fin_err;
  logic      fin_ok, fin_fail;
  logic      init_s, done_s;
  logic      tmr_clr;
  logic [TMR_W-1:0] cnt;
  logic      ser_load, ser_busy, ser_pulse_end;
  logic [BYTE_W-1:0] ser_byte;
  logic      last_seen, armed, accept;
  logic [TRAIL_W-1:0] trail;
  logic [1:0] pins_s;

  sscfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .d({cfg_done, cfg_init_n}), .q(pins_s)
  );
  assign init_s = pins_s[0];
  assign done_s = pins_s[1];

  sscfg_cycle_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .cnt(cnt)
  );

  sscfg_shifter #(.HALF(CCLK_HALF), .W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .load(ser_load), .load_byte(ser_byte),
    .stop(fin_ok || fin_fail), .cclk(cfg_cclk), .din(cfg_din),
    .busy(ser_busy), .pulse_end(ser_pulse_end)
  );

  assign s_ready = (st == LD_STREAM) && !ser_busy && init_s && !done_s && !last_seen;
  assign accept  = s_ready && s_valid;

  always_comb begin
    st_n     = st;
    fin_ok   = 1'b0;
    fin_fail = 1'b0;
    fin_err  = ERR_NONE;
    ser_load = 1'b0;
    ser_byte = '1;
    case (st)
      LD_IDLE: if (start) st_n = LD_PROG;
      LD_PROG: begin
        if (cnt >= PROG_END && !init_s) st_n = LD_WAIT_INIT;
        else if (cnt >= INIT_END) begin
          fin_fail = 1'b1;
          fin_err  = ERR_NO_INIT_LOW;
        end
      end
      LD_WAIT_INIT: begin
        if (init_s) st_n = LD_STREAM;
        else if (cnt >= INIT_END) begin
          fin_fail = 1'b1;
          fin_err  = ERR_NO_INIT_HIGH;
        end
      end
      LD_STREAM: begin
        if (!init_s) begin
          fin_fail = 1'b1;
          fin_err  = ERR_CRC;
        end else if (!ser_busy && (last_seen || done_s)) begin
          st_n = LD_FINISH;
        end else if (accept) begin
          ser_load = 1'b1;
          ser_byte = s_data;
        end
      end
      LD_FINISH: begin
        if (ser_pulse_end && armed && trail == TRAIL_END) fin_ok = 1'b1;
        else if (cnt >= CFG_END) begin
          fin_fail = 1'b1;
          fin_err  = ERR_FINISH_TIMEOUT;
        end else if (!ser_busy) ser_load = 1'b1;
      end
      default: st_n = LD_IDLE;
    endcase
    if (fin_ok || fin_fail) st_n = LD_IDLE;
  end

  assign tmr_clr = (st_n != st);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= LD_IDLE;
      cfg_prog_n <= 1'b1;
      busy       <= 1'b0;
      load_ok    <= 1'b0;
      load_fail  <= 1'b0;
      err_q      <= ERR_NONE;
      last_seen  <= 1'b0;
      armed      <= 1'b0;
      trail      <= '0;
    end else begin
      st <= st_n;
      if (st == LD_IDLE && start) begin
        load_ok    <= 1'b0;
        load_fail  <= 1'b0;
        err_q      <= ERR_NONE;
        busy       <= 1'b1;
        cfg_prog_n <= 1'b0;
        last_seen  <= 1'b0;
        armed      <= 1'b0;
        trail      <= '0;
      end
      if (st == LD_PROG && st_n == LD_WAIT_INIT) cfg_prog_n <= 1'b1;
      if (accept && s_last) last_seen <= 1'b1;
      if (st == LD_FINISH && ser_pulse_end) begin
        if (armed) trail <= trail + 1'b1;
        else if (done_s && init_s) armed <= 1'b1;
      end
      if (fin_fail) begin
        load_fail  <= 1'b1;
        err_q      <= fin_err;
        busy       <= 1'b0;
        cfg_prog_n <= 1'b1;
      end
      if (fin_ok) begin
        load_ok <= 1'b1;
        busy    <= 1'b0;
      end
    end
  end

  assign err_code = err_q;
endmodule

// File: rtl/sscfg_loader_chk.sv
module sscfg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       s_ready,
  input logic       cfg_prog_n,
  input logic       cfg_cclk,
  input logic       cfg_din,
  input logic       load_ok,
  input logic       load_fail,
  input logic [2:0] err_code
);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cfg_prog_n && cfg_cclk));

  p_prog_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_prog_n |-> busy);

  p_fail_has_code_r3: assert property (@(posedge clk) disable iff (rst)
    load_fail |-> (err_code != 3'd0));

  p_ready_gated_r4: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (busy && cfg_prog_n));

  p_din_stable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_cclk) |-> $stable(cfg_din));

  p_ok_clean_r8: assert property (@(posedge clk) disable iff (rst)
    load_ok |-> (err_code == 3'd0 && !load_fail));

  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (load_fail && !start) |=> load_fail);

  p_ok_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (load_ok && !start) |=> load_ok);
endmodule

bind sscfg_loader sscfg_loader_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .s_ready(s_ready),
  .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
  .load_ok(load_ok), .load_fail(load_fail), .err_code(err_code)
);

// File: tb/sim_sscfg_loader.sv
module sim_sscfg_loader;
  localparam int HALF = 4;
  localparam int PROGC = 20;
  localparam int INITTO = 300;
  localparam int CFGTO = 1500;
  localparam int TRAIL = 8;

  logic clk = 0, rst = 1, start = 0;
  logic [7:0] s_data = 0;
  logic s_valid = 0, s_last = 0, s_ready;
  logic cfg_prog_n, cfg_init_n = 1, cfg_done = 0, cfg_cclk, cfg_din;
  logic busy, load_ok, load_fail;
  logic [2:0] err_code;

  always #2 clk = ~clk;

  sscfg_loader #(.CCLK_HALF(HALF), .PROG_CYCLES(PROGC), .INIT_TIMEOUT(INITTO),
    .CONFIG_TIMEOUT(CFGTO), .TRAIL_CLKS(TRAIL), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .cfg_prog_n(cfg_prog_n),
    .cfg_init_n(cfg_init_n), .cfg_done(cfg_done), .cfg_cclk(cfg_cclk),
    .cfg_din(cfg_din), .busy(busy), .load_ok(load_ok), .load_fail(load_fail),
    .err_code(err_code));

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] tx [64];
  logic [7:0] rx [64];
  int tx_len = 0, tx_idx = 0, acc_cnt = 0, rx_n = 0, edge_cnt = 0;
  bit feed_en = 0, pend_acc = 0;
  bit mdl_low_en = 1, mdl_hi_en = 1, mdl_hold = 0;
  int mdl_low_dly = 3, mdl_hi_dly = 5, prog_low_cnt = 0, prog_width = 0, rel_cnt = 0;
  logic init_at_rel = 1;
  int done_at_edge = -1, crc_at_edge = -1, edges_at_done = 0;
  bit done_req = 0, crc_req = 0;
  logic [7:0] shreg = 0;
  int low_run = 0, low_viol = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // target-side capture of the serial stream
  always @(posedge cfg_cclk) begin
    edge_cnt++;
    shreg = {shreg[6:0], cfg_din};
    if (edge_cnt % 8 == 0) begin
      if (rx_n < 64) rx[rx_n] = shreg;
      rx_n++;
    end
    if (edge_cnt == done_at_edge) done_req = 1;
    if (edge_cnt == crc_at_edge) crc_req = 1;
  end

  // target pin model
  always @(negedge clk) begin
    if (done_req) begin cfg_done = 1; done_req = 0; edges_at_done = edge_cnt; end
    if (crc_req) begin mdl_hold = 1; cfg_init_n = 0; crc_req = 0; end
    if (!cfg_prog_n) begin
      prog_low_cnt++;
      rel_cnt = 0;
      if (mdl_low_en && prog_low_cnt >= mdl_low_dly) cfg_init_n = 0;
    end else begin
      if (prog_low_cnt != 0) begin
        prog_width = prog_low_cnt;
        init_at_rel = cfg_init_n;
        prog_low_cnt = 0;
      end
      if (!cfg_init_n && !mdl_hold) begin
        rel_cnt++;
        if (mdl_hi_en && rel_cnt >= mdl_hi_dly) cfg_init_n = 1;
      end
    end
    if (!cfg_cclk) low_run++;
    else if (low_run != 0) begin
      if (low_run != HALF) low_viol++;
      low_run = 0;
    end
  end

  // byte stream feeder with random gaps
  always @(negedge clk) begin
    if (pend_acc) begin acc_cnt++; tx_idx++; end
    pend_acc = 0;
    if (feed_en && tx_idx < tx_len && ($urandom % 4 != 0)) begin
      s_valid = 1; s_data = tx[tx_idx]; s_last = (tx_idx == tx_len - 1);
    end else begin
      s_valid = 0; s_last = 0;
    end
    pend_acc = s_valid && s_ready;
  end

  task automatic prep(input int len);
    @(negedge clk);
    for (int i = 0; i < len; i++) tx[i] = 8'($urandom);
    tx_len = len; tx_idx = 0; acc_cnt = 0; rx_n = 0; edge_cnt = 0;
    cfg_done = 0; cfg_init_n = 1; mdl_hold = 0; mdl_low_en = 1; mdl_hi_en = 1;
    mdl_low_dly = 3; mdl_hi_dly = 5; done_at_edge = len * 8 + 1; crc_at_edge = -1;
    low_viol = 0; low_run = 0; edges_at_done = 0;
  endtask

  task automatic kick();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    feed_en = 1;
  endtask

  task automatic wait_end(input int ign_at);
    int n = 0;
    while (!(load_ok || load_fail) && n < 20000) begin
      @(negedge clk);
      n++;
      if (n == ign_at) start = 1;
      else start = 0;
    end
    start = 0;
    feed_en = 0;
    @(negedge clk);
  endtask

  task automatic check_good(input int len, input string tag);
    int mism = 0;
    for (int i = 0; i < len; i++) if (rx[i] !== tx[i]) mism++;
    chk(load_ok && !load_fail && err_code == 0, {tag, " R8 ok"}, int'(err_code), 0);
    chk(mism == 0, {tag, " R5 msb-first data"}, mism, 0);
    chk(low_viol == 0, {tag, " R5 low phase"}, low_viol, 0);
    chk(edge_cnt - edges_at_done == TRAIL, {tag, " R8 trailing edges"}, edge_cnt - edges_at_done, TRAIL);
    chk(acc_cnt == len, {tag, " R6 accepted"}, acc_cnt, len);
    chk(cfg_prog_n && cfg_cclk && !busy, {tag, " R10 idle pins"}, int'(cfg_cclk), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cfg_prog_n == 1, "R1 prog", int'(cfg_prog_n), 1);
    chk(cfg_cclk == 1, "R1 cclk", int'(cfg_cclk), 1);
    chk(!busy && !load_ok && !load_fail && !s_ready, "R1 flags", int'(busy), 0);
    chk(err_code == 0, "R1 err", int'(err_code), 0);

    // directed load with edge patterns
    prep(4);
    tx[0] = 8'hA5; tx[1] = 8'h01; tx[2] = 8'h80; tx[3] = 8'hFF;
    kick();
    wait_end(0);
    check_good(4, "directed");
    chk(prog_width == PROGC, "R2 prog width", prog_width, PROGC);
    chk(init_at_rel == 0, "R2 init low at release", int'(init_at_rel), 0);

    // late init fall stretches the program pulse
    prep(2);
    mdl_low_dly = 40;
    kick();
    wait_end(0);
    chk(prog_width >= 40 && prog_width >= PROGC, "R2 stretched pulse", prog_width, 40);
    chk(init_at_rel == 0, "R2 late release", int'(init_at_rel), 0);
    check_good(2, "late");

    // random loads; one carries an ignored start pulse
    for (int k = 0; k < 6; k++) begin
      int len = 1 + int'($urandom % 10);
      prep(len);
      mdl_hi_dly = 1 + int'($urandom % 60);
      mdl_low_dly = 1 + int'($urandom % 15);
      kick();
      wait_end(k == 2 ? 60 : 0);
      check_good(len, k == 2 ? "R10 start ignored" : "random");
    end

    // early done after byte 3
    prep(8);
    done_at_edge = 3 * 8;
    kick();
    wait_end(0);
    chk(acc_cnt == 3, "R6 early done accepted", acc_cnt, 3);
    chk(load_ok && err_code == 0, "R6 early done ok", int'(err_code), 0);
    chk(rx[0] == tx[0] && rx[1] == tx[1] && rx[2] == tx[2], "R6 early data", int'(rx[2]), int'(tx[2]));

    // checksum error after byte 2
    prep(8);
    done_at_edge = -1;
    crc_at_edge = 2 * 8;
    kick();
    wait_end(0);
    chk(load_fail && err_code == 3, "R7 crc code", int'(err_code), 3);
    chk(acc_cnt == 2, "R7 accepted", acc_cnt, 2);
    chk(cfg_prog_n && cfg_cclk, "R10 idle after abort", int'(cfg_cclk), 1);
    repeat (30) @(negedge clk);
    chk(load_fail && err_code == 3 && !load_ok, "R10 sticky fail", int'(err_code), 3);

    // init never falls
    prep(2);
    mdl_low_en = 0;
    kick();
    chk(busy && !load_fail && err_code == 0, "R10 start clears", int'(err_code), 0);
    wait_end(0);
    chk(load_fail && err_code == 1, "R3 code", int'(err_code), 1);
    chk(prog_width == INITTO, "R3 pulse to timeout", prog_width, INITTO);
    chk(cfg_prog_n == 1, "R3 prog high", int'(cfg_prog_n), 1);

    // init never rises
    prep(2);
    mdl_hi_en = 0;
    kick();
    wait_end(0);
    chk(load_fail && err_code == 2, "R4 code", int'(err_code), 2);
    chk(acc_cnt == 0 && edge_cnt == 0, "R4 nothing sent", edge_cnt, 0);

    // done never comes
    prep(3);
    done_at_edge = -1;
    kick();
    wait_end(0);
    chk(load_fail && err_code == 4, "R9 code", int'(err_code), 4);
    chk(acc_cnt == 3, "R9 data sent", acc_cnt, 3);
    chk(edge_cnt > 24, "R8 ones clocked", edge_cnt, 25);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule